// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block controls up to seven switchable power domains. Each domain has four control lines: clock enable, reset release (active-high "out of reset"), isolation and power-switch off request. Each line is held in its own register, one bit per domain, so software can drive every line by hand through a simple word-wide write port. A combinational read port returns any register. A two-flop synchronizer brings in the power-switch acknowledge of each domain, and the synchronized value can be read as status.

For the usual case, a hardware sequencer takes one command and carries out the whole shutdown or wake-up order for one domain. After each clock, isolation or reset step it waits a settle time given in cycles. It waits for the synchronized acknowledge before it moves past the switch step. If the acknowledge does not arrive within a parameterised cycle limit, it stops and raises a sticky error. While the sequencer owns a domain, software writes to that domain's control bits are dropped. Writes to the other domains still take effect.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, clock enable and reset release read all ones over NDOM bits, isolation and switch-off read zero, and status reads zero.
- R2: A write to offset 0x00 (clock enable), 0x04 (reset release), 0x08 (isolation) or 0x0C (switch-off) updates the matching output vector at the next clock edge. The same value reads back. Bits at or above NDOM read zero.
- R3: Offset 0x10 returns the acknowledge inputs delayed by two clock edges. Writes to 0x10 change nothing.
- R4: A shutdown command (offset 0x14, index in bits 7:0, bit 8 = 0, bit 31 = 1) clears the clock enable, then sets isolation, then clears reset release, then sets switch-off. Consecutive steps are SETTLE+1 cycles apart, where SETTLE = CYC_PER_US*SETTLE_US.
- R5: After the switch-off step, a shutdown ends only once the synchronized acknowledge of that domain reads 1.
- R6: A wake-up command (bit 8 = 1) clears switch-off and waits for the synchronized acknowledge to read 0. It then sets reset release, clears isolation and sets clock enable, with steps SETTLE+1 cycles apart. Busy falls SETTLE cycles after the clock step.
- R7: If the acknowledge wait lasts OFF_LIMIT cycles (shutdown) or ON_LIMIT cycles (wake-up), the sequence ends at once with the error flag set and later steps skipped.
- R8: The error flag (status bit 2) stays set until a write to offset 0x18 with bit 2 = 1. Writing 0 to that bit leaves it set.
- R9: While busy, writes to the four control registers leave the bit of the domain being sequenced unchanged. The other bits are written normally.
- R10: A start command given while busy, or one whose index is NDOM or more, is ignored.
- R11: Status at 0x18 holds busy in bit 0, done in bit 1 and error in bit 2. An accepted start clears done, and done is set when a sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| dom_clk_en | output | NDOM | Per-domain clock enable |
| dom_rst_n | output | NDOM | Per-domain reset release (0 = held in reset) |
| dom_iso | output | NDOM | Per-domain isolation enable |
| dom_pwr_dn | output | NDOM | Per-domain power-switch off request |
| dom_ack | input | NDOM | Per-domain power-switch acknowledge (1 = off), asynchronous |

## Verification
Register writes show on the outputs one edge after the write strobe, and the bench reads them at the following falling edge. Acknowledge status is due two edges after an input change, so the bench samples it once after one edge, where it must still read the old value, and once after two. During a sequence the bench counts falling edges from the start command and records the cycle at which each of the domain's four lines changes. It then compares the gaps between steps with SETTLE+1, the closing settle with SETTLE, and the length of a timed-out wait with the exact limit.

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int NDOM       = 7,
  parameter int CYC_PER_US = 200,
  parameter int SETTLE_US  = 5,
  parameter int OFF_LIMIT  = 1000,
  parameter int ON_LIMIT   = 10000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [4:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [NDOM-1:0] dom_clk_en,
  output logic [NDOM-1:0] dom_rst_n,
  output logic [NDOM-1:0] dom_iso,
  output logic [NDOM-1:0] dom_pwr_dn,
  input  logic [NDOM-1:0] dom_ack
);
  localparam int SETTLE = CYC_PER_US * SETTLE_US;
  localparam int IW     = (NDOM > 1) ? $clog2(NDOM) : 1;
  localparam int LIM    = (ON_LIMIT > OFF_LIMIT) ? ON_LIMIT : OFF_LIMIT;
  localparam int TOP    = (LIM > SETTLE) ? LIM : SETTLE;
  localparam int CW     = $clog2(TOP + 1);

  typedef enum logic [1:0] {S_IDLE, S_STEP, S_HOLD, S_ACK} st_t;

  st_t            st;
  logic [1:0]     step;
  logic           dir;
  logic [IW-1:0]  idx;
  logic [CW-1:0]  cnt;
  logic           done_q, err_q;
  logic [NDOM-1:0] clk_q, rel_q, iso_q, pdn_q, meta_q, sync_q;

  wire            busy    = (st != S_IDLE);
  wire [2:0]      sel     = bus_addr[4:2];
  wire [NDOM-1:0] wmask   = busy ? ~(NDOM'(1) << idx) : {NDOM{1'b1}};
  wire [NDOM-1:0] wd      = bus_wdata[NDOM-1:0];
  wire            start   = bus_wr && sel == 3'd5 && bus_wdata[31] && !busy &&
                            (int'(bus_wdata[7:0]) < NDOM);
  wire            ack_hit = (sync_q[idx] == !dir);
  wire [CW-1:0]   ack_lim = dir ? CW'(ON_LIMIT - 1) : CW'(OFF_LIMIT - 1);

  assign dom_clk_en = clk_q;
  assign dom_rst_n  = rel_q;
  assign dom_iso    = iso_q;
  assign dom_pwr_dn = pdn_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= dom_ack;
      sync_q <= meta_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_q <= '1;
      rel_q <= '1;
      iso_q <= '0;
      pdn_q <= '0;
    end else begin
      if (bus_wr)
        case (sel)
          3'd0: clk_q <= (clk_q & ~wmask) | (wd & wmask);
          3'd1: rel_q <= (rel_q & ~wmask) | (wd & wmask);
          3'd2: iso_q <= (iso_q & ~wmask) | (wd & wmask);
          3'd3: pdn_q <= (pdn_q & ~wmask) | (wd & wmask);
          default: ;
        endcase
      if (st == S_STEP)
        case ({dir, step})
          3'b000:  clk_q[idx] <= 1'b0;
          3'b001:  iso_q[idx] <= 1'b1;
          3'b010:  rel_q[idx] <= 1'b0;
          3'b011:  pdn_q[idx] <= 1'b1;
          3'b100:  pdn_q[idx] <= 1'b0;
          3'b101:  rel_q[idx] <= 1'b1;
          3'b110:  iso_q[idx] <= 1'b0;
          default: clk_q[idx] <= 1'b1;
        endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      step   <= 2'd0;
      dir    <= 1'b0;
      idx    <= '0;
      cnt    <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (bus_wr && sel == 3'd6 && bus_wdata[2]) err_q <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            st     <= S_STEP;
            step   <= 2'd0;
            dir    <= bus_wdata[8];
            idx    <= bus_wdata[IW-1:0];
            done_q <= 1'b0;
          end
        S_STEP: begin
          cnt <= '0;
          st  <= ((!dir && step == 2'd3) || (dir && step == 2'd0)) ? S_ACK : S_HOLD;
        end
        S_HOLD:
          if (cnt == CW'(SETTLE - 1)) begin
            cnt <= '0;
            if (dir && step == 2'd3) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              step <= step + 2'd1;
              st   <= S_STEP;
            end
          end else cnt <= cnt + 1'b1;
        default:
          if (ack_hit) begin
            if (dir) begin
              step <= 2'd1;
              st   <= S_STEP;
            end else begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end
          end else if (cnt == ack_lim) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else cnt <= cnt + 1'b1;
      endcase
    end

  always_comb
    case (sel)
      3'd0:    bus_rdata = 32'(clk_q);
      3'd1:    bus_rdata = 32'(rel_q);
      3'd2:    bus_rdata = 32'(iso_q);
      3'd3:    bus_rdata = 32'(pdn_q);
      3'd4:    bus_rdata = 32'(sync_q);
      3'd5:    bus_rdata = 32'(idx) | (32'(dir) << 8);
      3'd6:    bus_rdata = {29'd0, err_q, done_q, busy};
      default: bus_rdata = 32'd0;
    endcase

  // R4
  off_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK && !dir && $rose(pdn_q[idx])) |-> (iso_q[idx] && !clk_q[idx] && !rel_q[idx]));

  // R6
  on_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && dir && $rose(clk_q[idx])) |-> (rel_q[idx] && !iso_q[idx] && !pdn_q[idx]));

  // R9
  owned_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_HOLD || $past(st) == S_ACK) |->
      ($stable(clk_q[idx]) && $stable(rel_q[idx]) && $stable(iso_q[idx]) && $stable(pdn_q[idx])));

  // R7
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(st) == S_ACK);

  // R7
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_ACK |-> cnt <= ack_lim);

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(idx) && $stable(dir)));

  // R11
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done_q);
endmodule

// File: tb/pwr_seq_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_bench;
  localparam int ND = 7, CPU = 2, SET = CPU * 5, OFFL = 40, ONL = 80, LAT = 6;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = 5'h0;
  logic [31:0] bus_wdata = 32'h0, bus_rdata;
  logic [ND-1:0] dom_clk_en, dom_rst_n, dom_iso, dom_pwr_dn, dom_ack;
  logic [ND-1:0] stuck_hi = '0, stuck_lo = '0;
  logic [ND-1:0] pipe [LAT];
  int total = 0, fails = 0;
  int tc, ti, tr, tp, te;

  always #2.5 clk = ~clk;

  pwr_seq_ctrl #(.NDOM(ND), .CYC_PER_US(CPU), .SETTLE_US(5), .OFF_LIMIT(OFFL), .ON_LIMIT(ONL))
    u_pwr_seq_ctrl (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
                    .dom_clk_en, .dom_rst_n, .dom_iso, .dom_pwr_dn, .dom_ack);

  always @(posedge clk or negedge rst_n)
    if (!rst_n) for (int k = 0; k < LAT; k++) pipe[k] <= '0;
    else begin
      pipe[0] <= dom_pwr_dn;
      for (int k = 1; k < LAT; k++) pipe[k] <= pipe[k-1];
    end
  assign dom_ack = (pipe[LAT-1] | stuck_hi) & ~stuck_lo;

  localparam logic [4:0]  VA [10] = '{5'h00, 5'h00, 5'h04, 5'h04, 5'h08, 5'h08, 5'h0C, 5'h0C, 5'h00, 5'h00};
  localparam logic [31:0] VD [10] = '{32'h55, 32'hFFFF_FFFF, 32'h0F, 32'h7F, 32'h2A, 32'h00, 32'h11, 32'h00, 32'h80, 32'h7F};
  localparam logic [31:0] VE [10] = '{32'h55, 32'h7F, 32'h0F, 32'h7F, 32'h2A, 32'h00, 32'h11, 32'h00, 32'h00, 32'h7F};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic logic [ND-1:0] port_of(input logic [4:0] a);
    case (a)
      5'h00:   return dom_clk_en;
      5'h04:   return dom_rst_n;
      5'h08:   return dom_iso;
      default: return dom_pwr_dn;
    endcase
  endfunction

  task automatic watch(input int d);
    logic [3:0] prev, cur;
    int c = 0;
    tc = -1; ti = -1; tr = -1; tp = -1;
    bus_addr = 5'h18;
    prev = {dom_clk_en[d], dom_iso[d], dom_rst_n[d], dom_pwr_dn[d]};
    do begin
      @(negedge clk); c++;
      cur = {dom_clk_en[d], dom_iso[d], dom_rst_n[d], dom_pwr_dn[d]};
      if (cur[3] != prev[3] && tc < 0) tc = c;
      if (cur[2] != prev[2] && ti < 0) ti = c;
      if (cur[1] != prev[1] && tr < 0) tr = c;
      if (cur[0] != prev[0] && tp < 0) tp = c;
      prev = cur;
    end while (bus_rdata[0] && c < 5000);
    te = c;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (10) @(negedge clk);
    // R1 reset state
    check("R1 clk_en", 32'(dom_clk_en), 32'h7F);
    check("R1 rst_n", 32'(dom_rst_n), 32'h7F);
    check("R1 iso", 32'(dom_iso), 32'h0);
    check("R1 pwr_dn", 32'(dom_pwr_dn), 32'h0);
    rd(5'h18, r); check("R1 status", r, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 register table
    for (int i = 0; i < 10; i++) begin
      wr(VA[i], VD[i]);
      rd(VA[i], r);
      check("R2 readback", r, VE[i]);
      check("R2 output", 32'(port_of(VA[i])), VE[i]);
    end
    repeat (20) @(negedge clk);

    // R3 synchronizer latency and read-only status
    @(negedge clk); stuck_hi = 7'h40; bus_addr = 5'h10;
    @(negedge clk); check("R3 one edge", bus_rdata, 32'h0);
    @(negedge clk); check("R3 two edges", bus_rdata, 32'h40);
    wr(5'h10, 32'h0);
    rd(5'h10, r); check("R3 write ignored", r, 32'h40);
    stuck_hi = '0;
    repeat (4) @(negedge clk);

    // R4 R5 shutdown domain 2
    wr(5'h14, 32'h8000_0002);
    watch(2);
    check("R4 clk->iso gap", 32'(ti - tc), 32'(SET + 1));
    check("R4 iso->rst gap", 32'(tr - ti), 32'(SET + 1));
    check("R4 rst->pdn gap", 32'(tp - tr), 32'(SET + 1));
    check("R5 ack wait", 32'(te - tp >= LAT + 2), 32'h1);
    rd(5'h18, r); check("R5 R11 status done", r, 32'h2);
    check("R4 clk_en", 32'(dom_clk_en), 32'h7B);
    check("R4 rst_n", 32'(dom_rst_n), 32'h7B);
    check("R4 iso", 32'(dom_iso), 32'h04);
    check("R4 pwr_dn", 32'(dom_pwr_dn), 32'h04);

    // R6 wake-up domain 2
    wr(5'h14, 32'h8000_0102);
    watch(2);
    check("R6 pdn first", 32'(tp == 1), 32'h1);
    check("R6 ack wait", 32'(tr - tp >= LAT + 2), 32'h1);
    check("R6 rst->iso gap", 32'(ti - tr), 32'(SET + 1));
    check("R6 iso->clk gap", 32'(tc - ti), 32'(SET + 1));
    check("R6 final settle", 32'(te - tc), 32'(SET));
    check("R6 outputs", {dom_clk_en, dom_rst_n, dom_iso, dom_pwr_dn}, {7'h7F, 7'h7F, 7'h0, 7'h0});

    // R9 R10 R11 ownership while busy, domain 4
    wr(5'h14, 32'h8000_0004);
    rd(5'h18, r); check("R11 done cleared on start", r, 32'h1);
    wr(5'h08, 32'h10);
    rd(5'h08, r); check("R9 owned bit blocked", r, 32'h00);
    wr(5'h08, 32'h01);
    rd(5'h08, r); check("R9 other bit written", r, 32'h01);
    wr(5'h14, 32'h8000_0005);
    rd(5'h14, r); check("R10 busy start ignored", r, 32'h4);
    watch(4);
    check("R10 domain 5 untouched", 32'(dom_clk_en), 32'h6F);
    check("R9 final iso", 32'(dom_iso), 32'h11);
    wr(5'h08, 32'h10);
    wr(5'h14, 32'h8000_0104);
    watch(4);
    check("R6 domain 4 restored", 32'(dom_clk_en), 32'h7F);

    // R10 invalid index
    wr(5'h14, 32'h8000_0007);
    rd(5'h18, r); check("R10 index out of range", r, 32'h2);

    // R7 R8 shutdown timeout, domain 3
    stuck_lo = 7'h08;
    wr(5'h14, 32'h8000_0003);
    watch(3);
    check("R7 off wait length", 32'(te - tp), 32'(OFFL));
    rd(5'h18, r); check("R7 error set", r, 32'h6);
    check("R7 pdn set", 32'(dom_pwr_dn), 32'h08);
    wr(5'h18, 32'h3);
    rd(5'h18, r); check("R8 zero keeps error", r, 32'h6);
    wr(5'h18, 32'h4);
    rd(5'h18, r); check("R8 one clears error", r, 32'h2);

    // R7 wake-up timeout, domain 3
    stuck_lo = '0; stuck_hi = 7'h08;
    wr(5'h14, 32'h8000_0103);
    watch(3);
    check("R7 on wait length", 32'(te - tp), 32'(ONL));
    rd(5'h18, r); check("R7 on error set", r, 32'h6);
    check("R7 later steps skipped", 32'({dom_clk_en[3], dom_rst_n[3], dom_iso[3], dom_pwr_dn[3]}), 32'b0010);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule